// File: doc/BRIEF.md
# Bit-Serial Jitter-Attenuating Elastic Buffer

This block is a one-bit-wide elastic store. Serial data arrives on write strobes that may be jittery, gapped or bursty. It leaves on a smooth read strobe that the block makes itself by dividing a fast master clock. In steady state the divider runs at a nominal ratio of 16, so a 32.768 MHz master gives a 2.048 MHz output bit rate. Both sides run in the master clock domain. The incoming bit clock is presented as a synchronous enable.

A mode input sets the working depth. The 32-bit depth keeps delay low. The 128-bit depth absorbs large wander. At every read the fill level is compared against a window centred on half the depth. If the fill is above the window, the next read interval shortens to 15 master cycles. If it is below, the interval stretches to 17. Each such correction sets a sticky limit-trip flag. A bypass input removes the buffer, and the input then passes to the output with one register of delay.

Top module: `jitter_elastic_buf`

## Requirements
- R1: While `rst_n` is low, the block takes the reset state: `fill` equals half the selected depth (16 or 64), `limit_trip` is 0 and `rd_stb` is 0. The first `rd_stb` comes 16 clock edges after the last edge with `rst_n` low.
- R2: `rd_stb` is one clock wide. While the fill seen at each read stays inside the window, successive strobes are exactly 16 edges apart and `limit_trip` stays 0.
- R3: The output bits are the written bits in write order. After reset they are preceded by half-depth zero bits. `rd_bit` changes only in cycles where `rd_stb` is high.
- R4: `deep_mode` = 0 selects depth 32, with centre 16 and window 2..30 inclusive. `deep_mode` = 1 selects depth 128, with centre 64 and window 4..124 inclusive.
- R5: If the fill seen at a read is above the window's top, the next read follows after 15 edges, and `limit_trip` is 1 in the same cycle as that read's `rd_stb`.
- R6: If the fill seen at a read is below the window's bottom, the next read follows after 17 edges, and `limit_trip` is set the same way.
- R7: `limit_trip` stays 1 until a cycle with `trip_clr` high and no new trip. If a trip and a clear fall on the same edge, the flag stays 1.
- R8: While `bypass` is 1, `rd_stb` and `rd_bit` copy `wr_stb` and `wr_bit` with one cycle of delay, and the divider makes no strobes. After `bypass` drops, `fill` is half the depth and the first strobe comes 16 edges after the last bypass edge.
- R9: A change of `deep_mode` realigns the buffer at the next edge: `fill` becomes half the new depth and the divider restarts, so the next strobe comes 16 edges after that realigning edge.
- R10: Gapped or bursty writes whose average rate matches the read rate come out in order, and the strobe spacing stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominally 16x the bit rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| deep_mode | input | 1 | Depth select: 0 = 32 bits, 1 = 128 bits |
| bypass | input | 1 | 1 removes the buffer; input passes to output |
| wr_stb | input | 1 | Write enable from the incoming bit clock |
| wr_bit | input | 1 | Serial input data, taken when wr_stb is 1 |
| trip_clr | input | 1 | Synchronous clear of the limit-trip flag |
| rd_stb | output | 1 | One-cycle read strobe, the smoothed bit clock |
| rd_bit | output | 1 | Serial output data, held between strobes |
| fill | output | 8 | Unread bits in the store |
| limit_trip | output | 1 | Sticky flag: a 15 or 17 interval was used |

## Verification
The bench builds the block with its default parameters: depths 32 and 128, trip excursions 28 and 120, and a nominal divide of 16. With these values both trip windows can be reached within a few thousand cycles, by writing every 12 cycles (overfill) or every 20 cycles (drain). The large mode can also be pushed to a fill of 100, a level that would trip the small window, to show the large window is wider. The same small depth lets the bench time a trip and a clear so they land on the same read edge, and lets it exercise a refill burst right after an underfill trip.

// File: rtl/jeb_pkg.sv
// Shared types for the jitter-attenuating elastic buffer.
package jeb_pkg;
    // Read interval chosen at each read: nominal, shortened or stretched.
    typedef enum logic [1:0] {
        PER_NOM  = 2'd0,
        PER_FAST = 2'd1,
        PER_SLOW = 2'd2
    } per_sel_e;
endpackage

// File: rtl/jeb_store.sv
// Bit ring store with write and read pointers.
// Assumes: the ring size is a power of two and is the largest selectable depth.
// A realign places the read pointer 'half' behind the write pointer, counting the
// write made in the same cycle. The caller never reads while the store is empty.
module jeb_store #(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign,
    input  logic [PTR_W-1:0] half,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_en,
    output logic             head_bit,
    output logic [PTR_W:0]   fill
);
    localparam int RING = 1 << PTR_W;

    logic [RING-1:0]  ring_q;
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [PTR_W-1:0] wr_ptr_nxt;

    assign wr_ptr_nxt = wr_ptr_q + PTR_W'(wr_en);

    // Store the incoming bit and advance the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q   <= '0;
            wr_ptr_q <= '0;
        end else begin
            if (wr_en) begin
                ring_q[wr_ptr_q] <= wr_bit;
            end
            wr_ptr_q <= wr_ptr_nxt;
        end
    end

    // Place or advance the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= PTR_W'(0) - half;
        end else if (realign) begin
            rd_ptr_q <= wr_ptr_nxt - half;
        end else if (rd_en) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    // Expose the oldest unread bit and the current occupancy.
    always_comb begin
        head_bit = ring_q[rd_ptr_q];
        fill     = {1'b0, wr_ptr_q - rd_ptr_q};
    end

    assert_realign_centre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (fill == {1'b0, $past(half)}));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (fill != '0));
endmodule

// File: rtl/jeb_window.sv
// Fill window comparator.
// Assumes: depths are even, each trip excursion is below its depth, and the
// larger depth sets the pointer width. Gives the realign offset for the selected
// depth, and the read interval class the current fill calls for.
module jeb_window
    import jeb_pkg::*;
#(
    parameter int PTR_W       = 7,
    parameter int SMALL_DEPTH = 32,
    parameter int LARGE_DEPTH = 128,
    parameter int SMALL_TRIP  = 28,
    parameter int LARGE_TRIP  = 120
) (
    input  logic             deep_mode,
    input  logic [PTR_W:0]   fill,
    output logic [PTR_W-1:0] half,
    output per_sel_e         sel
);
    localparam int SMALL_MID = SMALL_DEPTH / 2;
    localparam int LARGE_MID = LARGE_DEPTH / 2;
    localparam int SMALL_HI  = SMALL_MID + SMALL_TRIP / 2;
    localparam int SMALL_LO  = SMALL_MID - SMALL_TRIP / 2;
    localparam int LARGE_HI  = LARGE_MID + LARGE_TRIP / 2;
    localparam int LARGE_LO  = LARGE_MID - LARGE_TRIP / 2;

    logic [PTR_W:0] hi_lim;
    logic [PTR_W:0] lo_lim;

    // Pick centre and limits for the selected depth.
    always_comb begin
        if (deep_mode) begin
            half   = PTR_W'(LARGE_MID);
            hi_lim = (PTR_W+1)'(LARGE_HI);
            lo_lim = (PTR_W+1)'(LARGE_LO);
        end else begin
            half   = PTR_W'(SMALL_MID);
            hi_lim = (PTR_W+1)'(SMALL_HI);
            lo_lim = (PTR_W+1)'(SMALL_LO);
        end
    end

    // Classify the fill against the window.
    always_comb begin
        if (fill > hi_lim) begin
            sel = PER_FAST;
        end else if (fill < lo_lim) begin
            sel = PER_SLOW;
        end else begin
            sel = PER_NOM;
        end
    end
endmodule

// File: rtl/jeb_divider.sv
// Read clock divider.
// Assumes: DIV_NOM >= 3. Counts down from (interval - 1) and flags the terminal
// count as 'tick'. At each tick it loads the interval named by 'sel': DIV_NOM-1,
// DIV_NOM or DIV_NOM+1. A restart forces the nominal interval from the next edge.
module jeb_divider
    import jeb_pkg::*;
#(
    parameter int DIV_NOM = 16,
    parameter int CNT_W   = $clog2(DIV_NOM + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  per_sel_e sel,
    output logic     tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // Count down and reload with the chosen interval.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= CNT_W'(DIV_NOM - 1);
        end else if (tick) begin
            unique case (sel)
                PER_FAST: cnt_q <= CNT_W'(DIV_NOM - 2);
                PER_SLOW: cnt_q <= CNT_W'(DIV_NOM);
                default:  cnt_q <= CNT_W'(DIV_NOM - 1);
            endcase
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_fast_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && sel == PER_FAST) |=> (cnt_q == CNT_W'(DIV_NOM - 2)));

    assert_slow_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && sel == PER_SLOW) |=> (cnt_q == CNT_W'(DIV_NOM)));

    assert_restart_nominal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == CNT_W'(DIV_NOM - 1)));
endmodule

// File: rtl/jeb_trip.sv
// Sticky limit-trip flag.
// Assumes: 'set' and 'clr' are single-cycle qualified events. When both occur in
// the same cycle, the set wins.
module jeb_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until a clear arrives without a new trip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= set | (flag & ~clr);
        end
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/jitter_elastic_buf.sv
// Bit-serial jitter-attenuating elastic buffer, top level.
// Assumes: everything runs on the master clock, the input bit clock arrives as
// the enable wr_stb, and reset is synchronous and active low. Bypass or a change
// of depth realigns the store to half depth and restarts the read divider.
module jitter_elastic_buf
    import jeb_pkg::*;
#(
    parameter int SMALL_DEPTH = 32,
    parameter int LARGE_DEPTH = 128,
    parameter int SMALL_TRIP  = 28,
    parameter int LARGE_TRIP  = 120,
    parameter int DIV_NOM     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          deep_mode,
    input  logic                          bypass,
    input  logic                          wr_stb,
    input  logic                          wr_bit,
    input  logic                          trip_clr,
    output logic                          rd_stb,
    output logic                          rd_bit,
    output logic [$clog2(LARGE_DEPTH):0]  fill,
    output logic                          limit_trip
);
    localparam int PTR_W = $clog2(LARGE_DEPTH);

    logic             deep_q;
    logic             realign;
    logic             tick;
    logic             rd_fire;
    logic             head_bit;
    logic [PTR_W-1:0] half;
    per_sel_e         sel;
    logic             trip_set;
    logic             out_load;
    logic             rd_stb_q;
    logic             rd_bit_q;

    // Remember the depth in use so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deep_q <= deep_mode;
        end else begin
            deep_q <= deep_mode;
        end
    end

    // Realign on bypass or depth change; read only on an unmasked divider tick.
    always_comb begin
        realign  = bypass | (deep_mode != deep_q);
        rd_fire  = tick & ~realign;
        trip_set = rd_fire & (sel != PER_NOM);
        out_load = bypass ? wr_stb : rd_fire;
    end

    jeb_store #(
        .PTR_W (PTR_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .realign  (realign),
        .half     (half),
        .wr_en    (wr_stb),
        .wr_bit   (wr_bit),
        .rd_en    (rd_fire),
        .head_bit (head_bit),
        .fill     (fill)
    );

    jeb_window #(
        .PTR_W       (PTR_W),
        .SMALL_DEPTH (SMALL_DEPTH),
        .LARGE_DEPTH (LARGE_DEPTH),
        .SMALL_TRIP  (SMALL_TRIP),
        .LARGE_TRIP  (LARGE_TRIP)
    ) window_i (
        .deep_mode (deep_mode),
        .fill      (fill),
        .half      (half),
        .sel       (sel)
    );

    jeb_divider #(
        .DIV_NOM (DIV_NOM)
    ) divider_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (realign),
        .sel     (sel),
        .tick    (tick)
    );

    jeb_trip trip_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (trip_set),
        .clr   (trip_clr),
        .flag  (limit_trip)
    );

    // Register the output strobe and bit: from the divider, or straight from input in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stb_q <= 1'b0;
            rd_bit_q <= 1'b0;
        end else begin
            rd_stb_q <= out_load;
            if (out_load) begin
                rd_bit_q <= bypass ? wr_bit : head_bit;
            end
        end
    end

    assign rd_stb = rd_stb_q;
    assign rd_bit = rd_bit_q;

    assert_bypass_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (rd_stb == $past(wr_stb)));

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> !rd_fire);

    assert_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_load |=> $stable(rd_bit));
endmodule

// File: tb/jitter_elastic_buf_tb_top.sv
`timescale 1ns/1ps
module jitter_elastic_buf_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       deep_mode = 1'b0;
    logic       bypass = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_bit = 1'b0;
    logic       trip_clr = 1'b0;
    logic       rd_stb;
    logic       rd_bit;
    logic [7:0] fill;
    logic       limit_trip;

    always #2.5 clk = ~clk;

    jitter_elastic_buf dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .deep_mode  (deep_mode),
        .bypass     (bypass),
        .wr_stb     (wr_stb),
        .wr_bit     (wr_bit),
        .trip_clr   (trip_clr),
        .rd_stb     (rd_stb),
        .rd_bit     (rd_bit),
        .fill       (fill),
        .limit_trip (limit_trip)
    );

    int    edge_n = 0;
    int    vectors = 0;
    int    fails = 0;
    bit    exp_q[$];
    bit    hold_bit = 1'b0;
    bit    exp_bit;
    bit    sb_on = 1'b0;
    bit    chk_nom = 1'b0;
    int    last_rd = 0;
    int    last_gap = 0;
    int    interval = 0;
    bit    jit = 1'b0;
    int    burst_left = 0;
    int    phase = 0;
    int    cur_gap = 16;
    string data_tag = "R3";

    always @(posedge clk) edge_n++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (edge_n == 100000) begin
            check(1'b0, "watchdog (all requirements)", edge_n, 0);
            summary();
        end
    end

    // Write stimulus: bursts first, then periodic writes with optional jitter.
    always @(negedge clk) begin
        bit b;
        if (burst_left > 0) begin
            b = 1'($urandom);
            wr_stb <= 1'b1;
            wr_bit <= b;
            if (sb_on) exp_q.push_back(b);
            burst_left--;
        end else if (interval > 0) begin
            phase++;
            if (phase >= cur_gap) begin
                b = 1'($urandom);
                wr_stb <= 1'b1;
                wr_bit <= b;
                if (sb_on) exp_q.push_back(b);
                phase = 0;
                cur_gap = jit ? interval + int'($urandom_range(8)) - 4 : interval;
            end else begin
                wr_stb <= 1'b0;
            end
        end else begin
            wr_stb <= 1'b0;
        end
    end

    // Output monitor: strobe spacing, scoreboard order and bit hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_stb) begin
                last_gap = edge_n - last_rd;
                last_rd  = edge_n;
                if (chk_nom) check(last_gap == 16, "R2 strobe spacing", last_gap, 16);
                if (sb_on) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, {data_tag, " scoreboard empty"}, 0, 1);
                    end else begin
                        exp_bit = exp_q.pop_front();
                        check(rd_bit == exp_bit, {data_tag, " data order"}, int'(rd_bit), int'(exp_bit));
                        hold_bit = exp_bit;
                    end
                end
            end else if (sb_on) begin
                check(rd_bit == hold_bit, "R3 bit held between strobes", int'(rd_bit), int'(hold_bit));
            end
        end
    end

    task automatic nclk();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_rd();
        do nclk(); while (!rd_stb);
    endtask

    task automatic do_reset(input bit mode);
        int half;
        half = mode ? 64 : 16;
        sb_on = 0; chk_nom = 0; interval = 0; burst_left = 0; jit = 0;
        bypass = 0; trip_clr = 0; deep_mode = mode; rst_n = 0;
        repeat (3) nclk();
        check(fill == 8'(half), "R1 reset fill", int'(fill), half);
        check(limit_trip == 1'b0, "R1 reset trip flag", int'(limit_trip), 0);
        check(rd_stb == 1'b0, "R1 reset strobe", int'(rd_stb), 0);
        exp_q.delete();
        repeat (half) exp_q.push_back(1'b0);
        hold_bit = 0; phase = 0; cur_gap = 16; data_tag = "R3";
        rst_n = 1;
        last_rd = edge_n;
        sb_on = 1;
    endtask

    // R1 R2 R3: nominal jittered writes in small mode.
    task automatic t_nominal_small();
        do_reset(1'b0);
        interval = 16; jit = 1;
        wait_rd();
        check(last_gap == 16, "R1 first strobe after reset", last_gap, 16);
        chk_nom = 1;
        repeat (2000) nclk();
        chk_nom = 0;
        check(limit_trip == 1'b0, "R2 no trip inside window", int'(limit_trip), 0);
        interval = 0;
    endtask

    // R10: bursts of four back-to-back writes every 64 cycles.
    task automatic t_gapped();
        do_reset(1'b0);
        data_tag = "R10";
        wait_rd();
        chk_nom = 1;
        for (int i = 0; i < 40; i++) begin
            burst_left = 4;
            repeat (64) nclk();
        end
        chk_nom = 0;
        check(limit_trip == 1'b0, "R10 bursty input stays in window", int'(limit_trip), 0);
    endtask

    // R5 R7: overfill in small mode, then set-versus-clear collision.
    task automatic t_high_trip();
        do_reset(1'b0);
        interval = 12; jit = 0;
        while (!limit_trip) nclk();
        check(rd_stb == 1'b1, "R5 trip raised with read strobe", int'(rd_stb), 1);
        check(fill > 8'd29, "R5 fill above upper limit", int'(fill), 30);
        wait_rd();
        check(last_gap == 15, "R5 shortened interval", last_gap, 15);
        repeat (14) nclk();
        trip_clr = 1;
        nclk();
        check(rd_stb == 1'b1, "R5 next shortened read", int'(rd_stb), 1);
        check(last_gap == 15, "R5 interval stays shortened", last_gap, 15);
        check(limit_trip == 1'b1, "R7 set wins over clear", int'(limit_trip), 1);
        nclk();
        check(limit_trip == 1'b0, "R7 clear without trip", int'(limit_trip), 0);
        trip_clr = 0;
        interval = 0;
    endtask

    // R6 R7: drain in small mode, refill by burst after the trip.
    task automatic t_low_trip();
        do_reset(1'b0);
        interval = 20; jit = 0;
        while (!limit_trip) nclk();
        check(rd_stb == 1'b1, "R6 trip raised with read strobe", int'(rd_stb), 1);
        burst_left = 6;
        wait_rd();
        check(last_gap == 17, "R6 stretched interval", last_gap, 17);
        interval = 16; jit = 1;
        repeat (300) nclk();
        check(limit_trip == 1'b1, "R7 flag sticky without clear", int'(limit_trip), 1);
        trip_clr = 1;
        nclk();
        trip_clr = 0;
        check(limit_trip == 1'b0, "R7 flag cleared", int'(limit_trip), 0);
        interval = 0;
    endtask

    // R4: large window tolerates a fill the small window would reject.
    task automatic t_large_window();
        do_reset(1'b1);
        check(fill == 8'd64, "R4 large depth centre", int'(fill), 64);
        interval = 14; jit = 0;
        while (fill < 8'd100) nclk();
        check(limit_trip == 1'b0, "R4 no trip at fill 100 in large mode", int'(limit_trip), 0);
        interval = 0;
    endtask

    // R9: switch from large to small depth.
    task automatic t_realign();
        int e0;
        sb_on = 0; interval = 0;
        deep_mode = 1'b0;
        e0 = edge_n;
        nclk();
        check(fill == 8'd16, "R9 fill realigned to new centre", int'(fill), 16);
        wait_rd();
        check(edge_n - e0 == 17, "R9 divider restart", edge_n - e0, 17);
    endtask

    // R8: pass-through in bypass, realign on exit.
    task automatic t_bypass();
        bit stb_v[8] = '{1, 1, 0, 1, 0, 0, 1, 1};
        bit bit_v[8] = '{1, 0, 1, 1, 0, 1, 0, 1};
        int e0;
        sb_on = 0; interval = 0;
        bypass = 1;
        nclk();
        for (int i = 0; i < 8; i++) begin
            wr_stb = stb_v[i];
            wr_bit = bit_v[i];
            nclk();
            check(rd_stb == stb_v[i], "R8 bypass strobe", int'(rd_stb), int'(stb_v[i]));
            if (stb_v[i]) check(rd_bit == bit_v[i], "R8 bypass bit", int'(rd_bit), int'(bit_v[i]));
        end
        bypass = 0;
        e0 = edge_n;
        nclk();
        check(fill == 8'd16, "R8 fill centred after bypass", int'(fill), 16);
        wait_rd();
        check(edge_n - e0 == 16, "R8 first strobe after bypass", edge_n - e0, 16);
    endtask

    initial begin
        t_nominal_small();
        t_gapped();
        t_high_trip();
        t_low_trip();
        t_large_window();
        t_realign();
        t_bypass();
        summary();
    end
endmodule